// File: doc/BRIEF.md
# Serial Stream Time-Slot Interchanger

This block moves 8-bit channels between sixteen serial receive lines and sixteen serial transmit lines. Every channel arriving on any receive line is stored once per frame. Every transmit channel slot can carry any stored channel of the previous frame, chosen by a per-slot routing entry. The shift clock runs at twice the bit rate, so each bit cell lasts two clock cycles. A two-bit rate setting picks 32, 64 or 128 channels per frame. At 128 channels, 2048 input channels are switched to 2048 output channels.

A one-cycle frame pulse realigns the bit and channel counters. Without a pulse, the counters wrap by themselves at the end of each frame. The channel store has two halves. One frame is written into one half while the previous frame is read from the other, so every connection has a delay of exactly one frame. Each transmit line has its own enable output for a pad driver. A routing entry with its enable bit cleared leaves that slot undriven. Software uses a single write port to program the rate and the routing entries.

Top module: `tsi_switch`

## Requirements
- R1: While `rst_n` is low, every bit of `ser_oe` is 0. After reset, every routing enable is clear, so `ser_oe` stays 0 until entries are written, and the rate setting is code 0 (32 channels).
- R2: A high `frame_start` in one clock cycle makes the next cycle the first clock of bit 0 of channel 0.
- R3: Rate code 0 gives 32 channels per frame, code 1 gives 64 and code 2 gives 128. A frame lasts channels×16 clocks, and the counters return to channel 0 after the last channel without any frame pulse.
- R4: A rate write (`cfg_sel`=0) with `cfg_wdata[1:0]`=3 is ignored, and the previous rate stays in force.
- R5: Each receive line is sampled on the second clock of every bit cell. The first bit of a channel is its most significant bit.
- R6: Each transmit bit is held for both clocks of its bit cell. Bits go out most significant bit first, aligned with the same channel and bit counters as the receive side.
- R7: A routing write (`cfg_sel`=1) takes `cfg_addr`={out line[10:7], out channel[6:0]} and `cfg_wdata`={enable[11], source line[10:7], source channel[6:0]}. During frame k+1, that output slot carries the byte that arrived during frame k on the named source line and channel.
- R8: `ser_oe` of a line is high for the whole of a slot whose routing enable is set, and low for the whole of a slot whose enable is clear.
- R9: A route from the last channel of a frame to channel 0 of the next frame delivers the byte received in that last channel, even though the byte is stored in the same cycle that the slot is loaded.
- R10: A frame pulse in the middle of a frame restarts the frame. Data of the first complete frame after the pulse reaches the outputs during the frame that follows it.
- R11: A frame pulse that falls on the last clock of a frame leaves the switched data undisturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, two cycles per bit cell |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle frame alignment pulse |
| ser_in | input | 16 | Serial receive lines |
| ser_out | output | 16 | Serial transmit data |
| ser_oe | output | 16 | Transmit drive enables, high = driven |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = rate setting, 1 = routing entry |
| cfg_addr | input | 11 | Routing entry address |
| cfg_wdata | input | 12 | Write data (rate code or routing entry) |

## Verification
The hardest case is the frame boundary at which the last channel of the closing frame is stored in the same clock as channel 0 of the new frame is loaded for transmission. The routing pattern used at every rate sends transmit line 0, slot 0 to the last receive channel, so this boundary is checked once in every frame. The data is built from the frame number, line and channel. Any one-frame slip, wrong half of the store or missed forwarding therefore changes the expected byte. A frame pulse is also sent after an idle stretch of arbitrary length, which places it mid-frame, and another is sent on the final clock of a frame.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int TSI_STREAMS  = 16;
  localparam int TSI_STREAM_W = $clog2(TSI_STREAMS);
  localparam int TSI_CH_W     = 7;
  localparam int TSI_MAX_CH   = 1 << TSI_CH_W;
  localparam int TSI_BYTE_W   = 8;
  localparam int TSI_BIT_W    = $clog2(TSI_BYTE_W);
  localparam int TSI_CM_AW    = TSI_STREAM_W + TSI_CH_W;
  localparam int TSI_CM_DEPTH = 1 << TSI_CM_AW;
  localparam int TSI_DM_AW    = TSI_STREAM_W + 1 + TSI_CH_W;
  localparam int TSI_DM_DEPTH = 1 << TSI_DM_AW;
  localparam int TSI_RATE_W   = 2;
  localparam logic [TSI_RATE_W-1:0] TSI_RATE_RSVD = 2'b11;

  typedef struct packed {
    logic                    en;
    logic [TSI_STREAM_W-1:0] src;
    logic [TSI_CH_W-1:0]     ch;
  } route_t;

  localparam int TSI_ROUTE_W = $bits(route_t);

  // highest channel index of a frame for a given rate code
  function automatic logic [TSI_CH_W-1:0] tsi_last_channel(input logic [TSI_RATE_W-1:0] rate);
    logic [TSI_CH_W:0] count;
    case (rate)
      2'd0:    count = (TSI_CH_W+1)'(TSI_MAX_CH >> 2);
      2'd1:    count = (TSI_CH_W+1)'(TSI_MAX_CH >> 1);
      default: count = (TSI_CH_W+1)'(TSI_MAX_CH);
    endcase
    return TSI_CH_W'(count - 1'b1);
  endfunction
endpackage

// File: rtl/tsi_frame_timer.sv
module tsi_frame_timer
  import tsi_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_start,
  input  logic [TSI_RATE_W-1:0] rate,
  output logic                  cur_ph,
  output logic [TSI_BIT_W-1:0]  cur_bit,
  output logic [TSI_CH_W-1:0]   cur_ch,
  output logic                  cur_bank,
  output logic [TSI_BIT_W-1:0]  nxt_bit,
  output logic [TSI_CH_W-1:0]   nxt_ch,
  output logic                  nxt_bank,
  output logic                  byte_done
);
  logic                nxt_ph;
  logic [TSI_CH_W-1:0] last_ch;

  assign last_ch   = tsi_last_channel(rate);
  assign byte_done = cur_ph & (cur_bit == TSI_BIT_W'(TSI_BYTE_W - 1));

  always_comb begin
    nxt_ph   = cur_ph;
    nxt_bit  = cur_bit;
    nxt_ch   = cur_ch;
    nxt_bank = cur_bank;
    if (frame_start) begin
      nxt_ph   = 1'b0;
      nxt_bit  = '0;
      nxt_ch   = '0;
      nxt_bank = ~cur_bank;
    end else if (!cur_ph) begin
      nxt_ph = 1'b1;
    end else begin
      nxt_ph = 1'b0;
      if (cur_bit == TSI_BIT_W'(TSI_BYTE_W - 1)) begin
        nxt_bit = '0;
        if (cur_ch >= last_ch) begin
          nxt_ch   = '0;
          nxt_bank = ~cur_bank;
        end else begin
          nxt_ch = cur_ch + 1'b1;
        end
      end else begin
        nxt_bit = cur_bit + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_ph   <= 1'b0;
      cur_bit  <= '0;
      cur_ch   <= '0;
      cur_bank <= 1'b0;
    end else begin
      cur_ph   <= nxt_ph;
      cur_bit  <= nxt_bit;
      cur_ch   <= nxt_ch;
      cur_bank <= nxt_bank;
    end
  end
endmodule

// File: rtl/tsi_rx_capture.sv
module tsi_rx_capture
  import tsi_pkg::*;
(
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    sample_en,
  input  logic [TSI_STREAMS-1:0]                  ser_in,
  output logic [TSI_STREAMS-1:0][TSI_BYTE_W-1:0]  cap_byte
);
  for (genvar s = 0; s < TSI_STREAMS; s++) begin : g_lane
    logic [TSI_BYTE_W-2:0] shift_q;
    logic [TSI_BYTE_W-2:0] shift_d;

    always_comb begin
      shift_d = shift_q;
      if (sample_en) shift_d = {shift_q[TSI_BYTE_W-3:0], ser_in[s]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shift_q <= '0;
      else        shift_q <= shift_d;
    end

    // full byte as it stands once the current line value is sampled
    assign cap_byte[s] = {shift_q, ser_in[s]};
  end
endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem
  import tsi_pkg::*;
(
  input  logic                                     clk,
  input  logic                                     wr_en,
  input  logic                                     wr_bank,
  input  logic [TSI_CH_W-1:0]                      wr_ch,
  input  logic [TSI_STREAMS-1:0][TSI_BYTE_W-1:0]   wr_bytes,
  input  logic                                     rd_bank,
  input  logic [TSI_STREAMS-1:0][TSI_STREAM_W-1:0] rd_src,
  input  logic [TSI_STREAMS-1:0][TSI_CH_W-1:0]     rd_ch,
  output logic [TSI_STREAMS-1:0][TSI_BYTE_W-1:0]   rd_bytes
);
  logic [TSI_BYTE_W-1:0] store [TSI_DM_DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int s = 0; s < TSI_STREAMS; s++) begin
        store[{TSI_STREAM_W'(s), wr_bank, wr_ch}] <= wr_bytes[s];
      end
    end
  end

  for (genvar o = 0; o < TSI_STREAMS; o++) begin : g_port
    logic fwd;
    assign fwd = wr_en && (rd_bank == wr_bank) && (rd_ch[o] == wr_ch);
    assign rd_bytes[o] = fwd ? wr_bytes[rd_src[o]]
                             : store[{rd_src[o], rd_bank, rd_ch[o]}];
  end
endmodule

// File: rtl/tsi_route_mem.sv
module tsi_route_mem
  import tsi_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [TSI_CM_AW-1:0]              wr_addr,
  input  route_t                            wr_data,
  input  logic [TSI_CH_W-1:0]               rd_ch,
  output route_t [TSI_STREAMS-1:0]          rd_entry
);
  localparam int PathW = TSI_STREAM_W + TSI_CH_W;

  logic [PathW-1:0]        path_mem [TSI_CM_DEPTH];
  logic [TSI_CM_DEPTH-1:0] en_q;
  logic [TSI_CM_DEPTH-1:0] en_d;

  always_ff @(posedge clk) begin
    if (wr_en) path_mem[wr_addr] <= {wr_data.src, wr_data.ch};
  end

  always_comb begin
    en_d = en_q;
    if (wr_en) en_d[wr_addr] = wr_data.en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  for (genvar o = 0; o < TSI_STREAMS; o++) begin : g_port
    logic [TSI_CM_AW-1:0] addr;
    logic [PathW-1:0]     path;
    assign addr        = {TSI_STREAM_W'(o), rd_ch};
    assign path        = path_mem[addr];
    assign rd_entry[o] = '{en: en_q[addr], src: path[PathW-1:TSI_CH_W], ch: path[TSI_CH_W-1:0]};
  end
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_start,
  input  logic [TSI_STREAMS-1:0] ser_in,
  output logic [TSI_STREAMS-1:0] ser_out,
  output logic [TSI_STREAMS-1:0] ser_oe,
  input  logic                   cfg_we,
  input  logic                   cfg_sel,
  input  logic [TSI_CM_AW-1:0]   cfg_addr,
  input  logic [TSI_ROUTE_W-1:0] cfg_wdata
);
  logic rst_meta_n, rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_core_n, rst_meta_n} <= 2'b00;
    else        {rst_core_n, rst_meta_n} <= {rst_meta_n, 1'b1};
  end

  // rate setting
  logic [TSI_RATE_W-1:0] rate_q, rate_d;
  logic                  rate_we;

  assign rate_we = cfg_we && !cfg_sel && (cfg_wdata[TSI_RATE_W-1:0] != TSI_RATE_RSVD);

  always_comb begin
    rate_d = rate_q;
    if (rate_we) rate_d = cfg_wdata[TSI_RATE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) rate_q <= '0;
    else             rate_q <= rate_d;
  end

  // frame counters
  logic                 cur_ph, cur_bank, nxt_bank, byte_done;
  logic [TSI_BIT_W-1:0] cur_bit, nxt_bit;
  logic [TSI_CH_W-1:0]  cur_ch, nxt_ch;

  tsi_frame_timer i_timer (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .frame_start(frame_start),
    .rate       (rate_q),
    .cur_ph     (cur_ph),
    .cur_bit    (cur_bit),
    .cur_ch     (cur_ch),
    .cur_bank   (cur_bank),
    .nxt_bit    (nxt_bit),
    .nxt_ch     (nxt_ch),
    .nxt_bank   (nxt_bank),
    .byte_done  (byte_done)
  );

  // receive side
  logic [TSI_STREAMS-1:0][TSI_BYTE_W-1:0] cap_byte;

  tsi_rx_capture i_rx (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .sample_en(cur_ph),
    .ser_in   (ser_in),
    .cap_byte (cap_byte)
  );

  // routing entries, looked up for the slot that starts next cycle
  route_t [TSI_STREAMS-1:0] route;

  tsi_route_mem i_route (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (cfg_we && cfg_sel),
    .wr_addr (cfg_addr),
    .wr_data (route_t'(cfg_wdata)),
    .rd_ch   (nxt_ch),
    .rd_entry(route)
  );

  // channel store, previous frame is read from the half not being filled
  logic [TSI_STREAMS-1:0][TSI_STREAM_W-1:0] rd_src;
  logic [TSI_STREAMS-1:0][TSI_CH_W-1:0]     rd_ch;
  logic [TSI_STREAMS-1:0][TSI_BYTE_W-1:0]   rd_bytes;

  for (genvar o = 0; o < TSI_STREAMS; o++) begin : g_sel
    assign rd_src[o] = route[o].src;
    assign rd_ch[o]  = route[o].ch;
  end

  tsi_data_mem i_store (
    .clk     (clk),
    .wr_en   (byte_done),
    .wr_bank (cur_bank),
    .wr_ch   (cur_ch),
    .wr_bytes(cap_byte),
    .rd_bank (~nxt_bank),
    .rd_src  (rd_src),
    .rd_ch   (rd_ch),
    .rd_bytes(rd_bytes)
  );

  // transmit registers
  logic [TSI_STREAMS-1:0] out_d, oe_d;

  always_comb begin
    for (int o = 0; o < TSI_STREAMS; o++) begin
      out_d[o] = rd_bytes[o][~nxt_bit];
      oe_d[o]  = route[o].en;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      ser_out <= '0;
      ser_oe  <= '0;
    end else begin
      ser_out <= out_d;
      ser_oe  <= oe_d;
    end
  end
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk
  import tsi_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   frame_start,
  input logic                   ph,
  input logic [TSI_BIT_W-1:0]   bit_idx,
  input logic [TSI_CH_W-1:0]    ch,
  input logic [TSI_RATE_W-1:0]  rate,
  input logic                   cfg_we,
  input logic                   cfg_sel,
  input logic [TSI_ROUTE_W-1:0] cfg_wdata,
  input logic [TSI_STREAMS-1:0] ser_oe
);
  logic [TSI_CH_W-1:0] top_ch;
  always_comb begin
    case (rate)
      2'd0:    top_ch = TSI_CH_W'((TSI_MAX_CH / 4) - 1);
      2'd1:    top_ch = TSI_CH_W'((TSI_MAX_CH / 2) - 1);
      default: top_ch = TSI_CH_W'(TSI_MAX_CH - 1);
    endcase
  end

  // R1: no line is driven while reset is held
  always @(posedge clk) begin
    if (!rst_n) assert_oe_off_in_reset_R1: assert (ser_oe == '0);
  end

  // R2: frame pulse lands on channel 0, bit 0, first clock
  assert_frame_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (!ph && bit_idx == '0 && ch == '0));

  // R3: counters wrap to channel 0 at the end of the active frame
  assert_frame_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && ph && bit_idx == TSI_BIT_W'(TSI_BYTE_W - 1) && ch >= top_ch) |=> (ch == '0));

  // R4: reserved rate code leaves the rate unchanged
  assert_rate_rsvd_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_sel && cfg_wdata[TSI_RATE_W-1:0] == TSI_RATE_RSVD) |=> $stable(rate));

  // R6: each bit cell lasts two clocks
  assert_bit_cell_two_clocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && !ph) |=> (ph && $stable(bit_idx) && $stable(ch)));
endmodule

bind tsi_switch tsi_switch_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .frame_start(frame_start),
  .ph         (cur_ph),
  .bit_idx    (cur_bit),
  .ch         (cur_ch),
  .rate       (rate_q),
  .cfg_we     (cfg_we),
  .cfg_sel    (cfg_sel),
  .cfg_wdata  (cfg_wdata),
  .ser_oe     (ser_oe)
);

// File: tb/test_tsi_switch.sv
module test_tsi_switch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        frame_start = 1'b0;
  logic [15:0] ser_in = '0;
  logic [15:0] ser_out, ser_oe;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [10:0] cfg_addr = '0;
  logic [11:0] cfg_wdata = '0;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  tsi_switch i_tsi_switch (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .ser_in(ser_in),
    .ser_out(ser_out), .ser_oe(ser_oe), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // routing pattern, arithmetic in line, channel and channel count
  function automatic bit r_en(int o, int c);
    return ((o * 3 + c) % 7) != 2;
  endfunction
  function automatic int r_src(int o, int c);
    return (o * 5 + c * 3 + 1) % 16;
  endfunction
  function automatic int r_sch(int o, int c, int nch);
    return nch - 1 - ((c * 7 + o * 3) % nch);
  endfunction
  function automatic logic [7:0] pat(int f, int s, int c);
    return 8'((f * 59 + s * 23 + c * 7 + 11) ^ ((c * 3) >> 1));
  endfunction

  task automatic cfg_write(input bit sel, input int addr, input int data);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_sel = sel; cfg_addr = 11'(addr); cfg_wdata = 12'(data);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic program_routes(input int nch);
    for (int o = 0; o < 16; o++) begin
      for (int c = 0; c < nch; c++) begin
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_sel = 1'b1;
        cfg_addr  = {4'(o), 7'(c)};
        cfg_wdata = {r_en(o, c), 4'(r_src(o, c)), 7'(r_sch(o, c, nch))};
      end
    end
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  // pulse, then run nfr frames; frames from index 1 on are checked
  task automatic run_frames(input int nch, input int nfr, input string tag, input bit end_pulse);
    @(posedge clk); #1;
    frame_start = 1'b1;
    for (int f = 0; f < nfr; f++) begin
      for (int c = 0; c < nch; c++) begin
        logic [15:0]      oe_and, oe_or, first, held_bad;
        logic [15:0][7:0] got;
        oe_and = '1; oe_or = '0; held_bad = '0; first = '0; got = '0;
        for (int b = 0; b < 8; b++) begin
          for (int p = 0; p < 2; p++) begin
            @(posedge clk); #1;
            frame_start = end_pulse && f == 1 && c == nch - 1 && b == 7 && p == 1;
            for (int s = 0; s < 16; s++) begin
              logic [7:0] v;
              v = pat(f, s, c);
              ser_in[s] = v[7 - b];
            end
            #4;
            oe_and &= ser_oe;
            oe_or  |= ser_oe;
            if (p == 0) first = ser_out;
            else begin
              held_bad |= first ^ ser_out;
              for (int o = 0; o < 16; o++) got[o][7 - b] = ser_out[o];
            end
          end
        end
        if (f >= 1) begin
          for (int o = 0; o < 16; o++) begin
            bit         en;
            logic [7:0] exp;
            en  = r_en(o, c);
            exp = pat(f - 1, r_src(o, c), r_sch(o, c, nch));
            check(oe_and[o] == en && oe_or[o] == en,
                  $sformatf("R2 R8 %s oe line %0d ch %0d", tag, o, c), {oe_or[o], oe_and[o]}, {en, en});
            if (en) begin
              check(!held_bad[o], $sformatf("R6 %s hold line %0d ch %0d", tag, o, c), held_bad[o], 0);
              check(got[o] == exp,
                    $sformatf("R5 R7 %s%s data line %0d ch %0d", tag,
                              (o == 0 && c == 0) ? " R9" : "", o, c), got[o], exp);
            end
          end
        end
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #4 check(ser_oe == '0, "R1 oe during reset", ser_oe, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #4 check(ser_oe == '0, "R1 oe after reset", ser_oe, 0);

    // rate left at its reset value (32 channels)
    program_routes(32);
    run_frames(32, 3, "R1 R3 rate0", 1'b0);

    cfg_write(1'b0, 0, 1);
    program_routes(64);
    run_frames(64, 3, "R3 R11 rate1", 1'b1);

    cfg_write(1'b0, 0, 3);
    run_frames(64, 3, "R4 reserved", 1'b0);

    cfg_write(1'b0, 0, 2);
    program_routes(128);
    repeat (777) @(posedge clk);
    run_frames(128, 3, "R3 R10 rate2", 1'b0);

    // reset in mid operation
    repeat (123) @(posedge clk);
    #1 rst_n = 1'b0;
    #2 check(ser_oe == '0, "R1 oe on reset entry", ser_oe, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    begin
      logic [15:0] seen;
      seen = '0;
      for (int i = 0; i < 600; i++) begin
        @(posedge clk); #5;
        seen |= ser_oe;
      end
      check(seen == '0, "R1 enables cleared by reset", seen, 0);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule